// File: doc/BRIEF.md
# Reconfigurable Processing Cell

This block is one word-level processing element meant to be tiled into the rows of a pipelined compute array. Each row of cells forms one pipeline stage. Each cell picks up to three operands (A, B, C). An operand may come from the broadcast input-FIFO word, from one entry of a global register file, from the output of any cell in the row above, or from the cell's own local register. The cell then applies one fixed-point operation, in 16-bit or 8-bit width, signed or unsigned, and registers the result.

The cell holds two configuration layers. One layer drives execution. The other can be rewritten through a small address/data port at the same time, so a new setting is loaded while the current loop is still running. A layer-select input chooses the active layer. The change takes effect at a clock edge where the enable input is high. The local register can follow operand A to add one cycle of delay, or it can keep a constant coefficient taken from the configuration.

The design has no state machine. The only sequencing state is the active-layer flag, and its single transition is a layer swap on an enabled edge.

Top module: `rc_cell`

## Requirements
- R1: An active-low reset clears both configuration layers, the local register, the output register and the active-layer flag (layer 0). With the cleared configuration, an enabled edge passes the low byte of the FIFO word, zero-extended.
- R2: Configuration word 1 selects the operands. The source code for A is in bits [1:0], for B in [3:2] and for C in [5:4]: 0 = FIFO, 1 = register file, 2 = row above, 3 = local register. The 2-bit indexes for A, B and C are in bits [7:6], [9:8] and [11:10]. An index picks the register-file entry or the upper-row column.
- R3: Configuration word 0 holds the opcode in bits [3:0], the 16-bit mode flag in bit 4, the signed flag in bit 5 and the shift amount in bits [9:6]. The codes are: 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR and 12 A+B+C. Results wrap modulo the word width.
- R4: Opcode 6 returns the low word of A*B. Opcode 7 returns the low word of A*B+C.
- R5: In 8-bit mode only the low bytes of the operands are used. The 8-bit result is sign-extended to 16 bits when the signed flag is set, and zero-extended when it is clear.
- R6: Opcode 9 shifts A left by the shift amount. Opcode 10 shifts A right, arithmetically when signed and logically when unsigned.
- R7: Opcode 11 adds half of an LSB, 2^(amount-1), to A and then shifts right by the amount. It is arithmetic when signed. A shift amount of 0 passes A unchanged.
- R8: Opcode 8 returns |A-B|. The comparison is signed or unsigned as the signed flag selects.
- R9: The output register and the local register load only on clock edges where enable is high. Otherwise they hold.
- R10: Configuration writes go to the layer that is not active and never change the active configuration, even while the cell executes.
- R11: The active layer follows the layer-select input only on an enabled edge. The result registered on the swap edge still uses the previous layer.
- R12: Local-register mode 1 (word 2 bits [1:0]) loads operand A on every enabled edge, which gives one cycle of delay.
- R13: Local-register mode 2 loads the coefficient from configuration word 3 on enabled edges. Mode 0 holds the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Execution enable; gates result, local register and layer swap |
| lyr_sel | input | 1 | Requested active configuration layer |
| cfg_en | input | 1 | Configuration write strobe (writes the inactive layer) |
| cfg_addr | input | 2 | Configuration word index 0..3 |
| cfg_data | input | 16 | Configuration word value |
| fifo_in | input | 16 | Broadcast input-FIFO word |
| grf_in | input | 64 | Global register file, entry i at bits [16i+15:16i] |
| row_in | input | 64 | Upper-row cell outputs, column i at bits [16i+15:16i] |
| pe_out | output | 16 | Registered result |
| lor_out | output | 16 | Local register value |

## Verification
A configuration write becomes visible on the edge that follows it, but it affects results only after a later swap. A swap needs two enabled edges before the new operation shows at `pe_out`: the swap edge registers a result from the old layer, and the next edge registers a result from the new layer. The bench drives inputs on falling edges and samples `pe_out` and `lor_out` on the falling edge after each result edge. It checks the swap-edge value separately. Local-register loads show one edge after the enabled edge that captures them, so delay and coefficient checks read `lor_out` after that edge and before any other stimulus.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [3:0] {
        OP_PASS  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_MUL   = 4'd6,
        OP_MAC   = 4'd7,
        OP_ABSD  = 4'd8,
        OP_SHL   = 4'd9,
        OP_SHR   = 4'd10,
        OP_SHRND = 4'd11,
        OP_ADD3  = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        SRC_FIFO = 2'd0,
        SRC_GRF  = 2'd1,
        SRC_ROW  = 2'd2,
        SRC_LOR  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        LOR_HOLD  = 2'd0,
        LOR_DELAY = 2'd1,
        LOR_COEF  = 2'd2,
        LOR_RSVD  = 2'd3
    } lor_e;

    localparam int CFG_WORDS  = 4;
    localparam int FLD_W16    = 4;
    localparam int FLD_SGN    = 5;
    localparam int FLD_SHAMT  = 6;
    localparam int FLD_IDX    = 6;

endpackage

// File: rtl/rc_cfg_layers.sv
module rc_cfg_layers #(
    parameter int CFGW  = 16,
    parameter int NWORD = 4,
    localparam int AW   = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   lyr_sel,
    input  logic                   cfg_en,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [CFGW-1:0]        cfg_data,
    output logic [NWORD*CFGW-1:0]  act_words
);

    logic act_q;

    // Active-layer flag: the single transition is a swap on an enabled edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            act_q <= 1'b0;
        else if (en)
            act_q <= lyr_sel;
    end

    for (genvar L = 0; L < 2; L++) begin : g_layer
        logic [NWORD*CFGW-1:0] words_q;
        logic                  wr_here;

        assign wr_here = cfg_en && (act_q != 1'(L));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words_q <= '0;
            else if (wr_here)
                words_q[int'(cfg_addr)*CFGW +: CFGW] <= cfg_data;
        end
    end

    assign act_words = act_q ? g_layer[1].words_q : g_layer[0].words_q;

    // R11: no layer change without enable
    p_swap_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(act_q));

    // R10: writes never disturb the running layer
    p_cfg_write_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !en) |=> $stable(act_words));

    // R11: an enabled edge lands on the requested layer
    p_swap_follows_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (act_q == $past(lyr_sel)));

endmodule

// File: rtl/rc_opnd_sel.sv
module rc_opnd_sel
    import rc_pkg::*;
#(
    parameter int W    = 16,
    parameter int NCOL = 4,
    parameter int NGRF = 4,
    parameter int IDXW = 2
) (
    input  src_e               kind,
    input  logic [IDXW-1:0]    idx,
    input  logic [W-1:0]       fifo_in,
    input  logic [NGRF*W-1:0]  grf_in,
    input  logic [NCOL*W-1:0]  row_in,
    input  logic [W-1:0]       lor_in,
    output logic [W-1:0]       opnd
);

    logic [W-1:0] grf_pick;
    logic [W-1:0] row_pick;

    always_comb begin
        grf_pick = '0;
        for (int i = 0; i < NGRF; i++)
            if (int'(idx) == i) grf_pick = grf_in[i*W +: W];
    end

    always_comb begin
        row_pick = '0;
        for (int i = 0; i < NCOL; i++)
            if (int'(idx) == i) row_pick = row_in[i*W +: W];
    end

    always_comb begin
        unique case (kind)
            SRC_FIFO: opnd = fifo_in;
            SRC_GRF:  opnd = grf_pick;
            SRC_ROW:  opnd = row_pick;
            SRC_LOR:  opnd = lor_in;
            default:  opnd = '0;
        endcase
    end

endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import rc_pkg::*;
#(
    parameter int W    = 16,
    localparam int H   = W / 2,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    input  op_e            op,
    input  logic           w16,
    input  logic           sgn,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   res
);

    function automatic logic [W-1:0] ext_half(input logic [W-1:0] x, input logic s);
        return s ? {{H{x[H-1]}}, x[H-1:0]} : {{H{1'b0}}, x[H-1:0]};
    endfunction

    logic [W-1:0] ea, eb, ec;
    logic [W-1:0] raw;
    logic [W-1:0] shr_v;
    logic [W-1:0] absd_v;
    logic [W:0]   xa, half, rsum, rsh;
    logic         a_lt_b;

    assign ea = w16 ? a : ext_half(a, sgn);
    assign eb = w16 ? b : ext_half(b, sgn);
    assign ec = w16 ? c : ext_half(c, sgn);

    always_comb begin
        if (sgn) a_lt_b = $signed(ea) < $signed(eb);
        else     a_lt_b = ea < eb;
        absd_v = a_lt_b ? (eb - ea) : (ea - eb);
    end

    always_comb begin
        if (sgn) shr_v = $signed(ea) >>> shamt;
        else     shr_v = ea >> shamt;
    end

    always_comb begin
        xa   = sgn ? {ea[W-1], ea} : {1'b0, ea};
        half = (shamt == '0) ? '0 : ((W+1)'(1) << (shamt - 1'b1));
        rsum = xa + half;
        if (sgn) rsh = $signed(rsum) >>> shamt;
        else     rsh = rsum >> shamt;
    end

    always_comb begin
        unique case (op)
            OP_PASS:  raw = ea;
            OP_ADD:   raw = ea + eb;
            OP_SUB:   raw = ea - eb;
            OP_AND:   raw = ea & eb;
            OP_OR:    raw = ea | eb;
            OP_XOR:   raw = ea ^ eb;
            OP_MUL:   raw = ea * eb;
            OP_MAC:   raw = ea * eb + ec;
            OP_ABSD:  raw = absd_v;
            OP_SHL:   raw = ea << shamt;
            OP_SHR:   raw = shr_v;
            OP_SHRND: raw = rsh[W-1:0];
            OP_ADD3:  raw = ea + eb + ec;
            default:  raw = '0;
        endcase
    end

    assign res = w16 ? raw : ext_half(raw, sgn);

endmodule

// File: rtl/rc_cell.sv
module rc_cell
    import rc_pkg::*;
#(
    parameter int W    = 16,
    parameter int NCOL = 4,
    parameter int NGRF = 4,
    parameter int CFGW = 16,
    localparam int NWORD = CFG_WORDS,
    localparam int AW    = $clog2(NWORD),
    localparam int SHW   = $clog2(W),
    localparam int MAXN  = (NCOL > NGRF) ? NCOL : NGRF,
    localparam int IDXW  = (MAXN > 1) ? $clog2(MAXN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               lyr_sel,
    input  logic               cfg_en,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [CFGW-1:0]    cfg_data,
    input  logic [W-1:0]       fifo_in,
    input  logic [NGRF*W-1:0]  grf_in,
    input  logic [NCOL*W-1:0]  row_in,
    output logic [W-1:0]       pe_out,
    output logic [W-1:0]       lor_out
);

    logic [NWORD*CFGW-1:0] act_words;
    logic [CFGW-1:0]       w0, w1, w2, w3;

    rc_cfg_layers #(.CFGW(CFGW), .NWORD(NWORD)) u_layers (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .lyr_sel   (lyr_sel),
        .cfg_en    (cfg_en),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .act_words (act_words)
    );

    assign w0 = act_words[0*CFGW +: CFGW];
    assign w1 = act_words[1*CFGW +: CFGW];
    assign w2 = act_words[2*CFGW +: CFGW];
    assign w3 = act_words[3*CFGW +: CFGW];

    op_e            op;
    logic           w16, sgn;
    logic [SHW-1:0] shamt;
    lor_e           lmode;
    logic [W-1:0]   coef;
    logic [W-1:0]   lor_q;
    logic [W-1:0]   res_q;
    logic [W-1:0]   alu_res;
    logic [W-1:0]   opnd [3];

    assign op    = op_e'(w0[3:0]);
    assign w16   = w0[FLD_W16];
    assign sgn   = w0[FLD_SGN];
    assign shamt = w0[FLD_SHAMT +: SHW];
    assign lmode = lor_e'(w2[1:0]);
    assign coef  = w3[W-1:0];

    logic unused_cfg;
    assign unused_cfg = ^{w0, w1, w2, w3};

    for (genvar i = 0; i < 3; i++) begin : g_opnd
        src_e            kind;
        logic [IDXW-1:0] idx;

        assign kind = src_e'(w1[2*i +: 2]);
        assign idx  = w1[FLD_IDX + i*IDXW +: IDXW];

        rc_opnd_sel #(.W(W), .NCOL(NCOL), .NGRF(NGRF), .IDXW(IDXW)) u_sel (
            .kind    (kind),
            .idx     (idx),
            .fifo_in (fifo_in),
            .grf_in  (grf_in),
            .row_in  (row_in),
            .lor_in  (lor_q),
            .opnd    (opnd[i])
        );
    end

    rc_alu #(.W(W)) u_alu (
        .a     (opnd[0]),
        .b     (opnd[1]),
        .c     (opnd[2]),
        .op    (op),
        .w16   (w16),
        .sgn   (sgn),
        .shamt (shamt),
        .res   (alu_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (en)
            res_q <= alu_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lor_q <= '0;
        else if (en) begin
            unique case (lmode)
                LOR_DELAY: lor_q <= opnd[0];
                LOR_COEF:  lor_q <= coef;
                default:   lor_q <= lor_q;
            endcase
        end
    end

    assign pe_out  = res_q;
    assign lor_out = lor_q;

    // R9: output holds when disabled
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pe_out));

    // R9: local register holds when disabled
    p_lor_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(lor_out));

    // R12: delay mode tracks operand A by one edge
    p_lor_delay_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lmode == LOR_DELAY) |=> (lor_out == $past(opnd[0])));

    // R13: coefficient mode loads the configured constant
    p_lor_coef_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lmode == LOR_COEF) |=> (lor_out == $past(coef)));

    // R13: hold mode keeps the register
    p_lor_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lmode == LOR_HOLD) |=> $stable(lor_out));

endmodule

// File: tb/rc_cell_bench.sv
module rc_cell_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic        lyr_sel;
    logic        cfg_en;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_data;
    logic [15:0] fifo_in;
    logic [63:0] grf_in;
    logic [63:0] row_in;
    logic [15:0] pe_out;
    logic [15:0] lor_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    logic cur = 1'b0;

    always #4 clk = ~clk;

    rc_cell u_rc_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .lyr_sel  (lyr_sel),
        .cfg_en   (cfg_en),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .fifo_in  (fifo_in),
        .grf_in   (grf_in),
        .row_in   (row_in),
        .pe_out   (pe_out),
        .lor_out  (lor_out)
    );

    // {req, w0, w1, a, b, c, expected}; a -> FIFO, b -> grf[1], c -> row[2]
    localparam int NV = 25;
    localparam logic [103:0] VEC [NV] = '{
        {8'd3, 16'h0011, 16'h0924, 16'h1234, 16'h0F0F, 16'h0000, 16'h2143}, // R3 add
        {8'd3, 16'h0012, 16'h0924, 16'h0005, 16'h0007, 16'h0000, 16'hFFFE}, // R3 sub wrap
        {8'd3, 16'h0013, 16'h0924, 16'hF0F0, 16'h3C3C, 16'h0000, 16'h3030}, // R3 and
        {8'd3, 16'h0014, 16'h0924, 16'hF0F0, 16'h3C3C, 16'h0000, 16'hFCFC}, // R3 or
        {8'd3, 16'h0015, 16'h0924, 16'hF0F0, 16'h3C3C, 16'h0000, 16'hCCCC}, // R3 xor
        {8'd4, 16'h0016, 16'h0924, 16'h0123, 16'h0100, 16'h0000, 16'h2300}, // R4 mul low
        {8'd4, 16'h0017, 16'h0924, 16'h0003, 16'h0004, 16'h0010, 16'h001C}, // R4 mac
        {8'd5, 16'h0001, 16'h0924, 16'h12F0, 16'h3420, 16'h0000, 16'h0010}, // R5 8b unsigned
        {8'd5, 16'h0021, 16'h0924, 16'h0070, 16'h0020, 16'h0000, 16'hFF90}, // R5 8b signed
        {8'd5, 16'h0026, 16'h0924, 16'h00FE, 16'h0003, 16'h0000, 16'hFFFA}, // R5 8b signed mul
        {8'd8, 16'h0018, 16'h0924, 16'h0003, 16'h000A, 16'h0000, 16'h0007}, // R8 unsigned
        {8'd8, 16'h0038, 16'h0924, 16'hFFFB, 16'h0004, 16'h0000, 16'h0009}, // R8 signed
        {8'd8, 16'h0008, 16'h0924, 16'h0010, 16'h00F0, 16'h0000, 16'h00E0}, // R8 8b
        {8'd6, 16'h0119, 16'h0924, 16'h0ABC, 16'h0000, 16'h0000, 16'hABC0}, // R6 shl 4
        {8'd6, 16'h00FA, 16'h0924, 16'h8010, 16'h0000, 16'h0000, 16'hF002}, // R6 sra 3
        {8'd6, 16'h00DA, 16'h0924, 16'h8010, 16'h0000, 16'h0000, 16'h1002}, // R6 srl 3
        {8'd7, 16'h009B, 16'h0924, 16'h0006, 16'h0000, 16'h0000, 16'h0002}, // R7 round up
        {8'd7, 16'h00BB, 16'h0924, 16'hFFFA, 16'h0000, 16'h0000, 16'hFFFF}, // R7 signed
        {8'd7, 16'h001B, 16'h0924, 16'h1235, 16'h0000, 16'h0000, 16'h1235}, // R7 amount 0
        {8'd7, 16'h004B, 16'h0924, 16'h00FF, 16'h0000, 16'h0000, 16'h0080}, // R7 8b
        {8'd3, 16'h001C, 16'h0924, 16'h0001, 16'h0002, 16'h0003, 16'h0006}, // R3 add3
        {8'd2, 16'h0010, 16'h00C2, 16'h0001, 16'h0000, 16'h0000, 16'h9999}, // R2 row[3]
        {8'd2, 16'h0010, 16'h0081, 16'h0001, 16'h0000, 16'h0000, 16'h5555}, // R2 grf[2]
        {8'd2, 16'h0010, 16'h0041, 16'h0001, 16'h0ACE, 16'h0000, 16'h0ACE}, // R2 grf[1]
        {8'd2, 16'h0010, 16'h0002, 16'h0001, 16'h0000, 16'h0000, 16'h7777}  // R2 row[0]
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_data(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        fifo_in = a;
        grf_in  = {16'h6666, 16'h5555, b, 16'h4444};
        row_in  = {16'h9999, c, 16'h8888, 16'h7777};
    endtask

    task automatic write_layer(input logic [15:0] w0, input logic [15:0] w1,
                               input logic [15:0] w2, input logic [15:0] w3);
        for (int i = 0; i < 4; i++) begin
            cfg_en   = 1'b1;
            cfg_addr = 2'(i);
            cfg_data = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : w3;
            @(negedge clk);
        end
        cfg_en = 1'b0;
    endtask

    // swap edge then one execution edge with the new layer
    task automatic swap_run(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        set_data(a, b, c);
        lyr_sel = ~cur;
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        cur = ~cur;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [103:0] v;
        rst_n = 1'b0; en = 1'b0; lyr_sel = 1'b0; cfg_en = 1'b0;
        cfg_addr = '0; cfg_data = '0;
        set_data(16'h0, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: cleared state
        check("R1 pe_out reset", pe_out, 16'h0000);
        check("R1 lor_out reset", lor_out, 16'h0000);
        fifo_in = 16'hABCD; en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        check("R1 cleared config passes zero-extended low byte", pe_out, 16'h00CD);

        // R9: disabled edges hold
        fifo_in = 16'h1111;
        repeat (2) @(negedge clk);
        check("R9 output holds without enable", pe_out, 16'h00CD);

        // table walk (R2..R8)
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            write_layer(v[95:80], v[79:64], 16'h0000, 16'h0000);
            swap_run(v[63:48], v[47:32], v[31:16]);
            check($sformatf("R%0d vector %0d", v[103:96], i), pe_out, v[15:0]);
        end

        // R11: swap edge still uses the old layer (PASS row[0])
        write_layer(16'h0011, 16'h0924, 16'h0000, 16'h0000);
        set_data(16'h0100, 16'h0001, 16'h0000);
        lyr_sel = ~cur; en = 1'b1;
        @(negedge clk);
        check("R11 swap edge uses previous layer", pe_out, 16'h7777);
        @(negedge clk);
        check("R11 next edge uses new layer", pe_out, 16'h0101);
        en = 1'b0; cur = ~cur;

        // R11: select change without enable does not swap
        write_layer(16'h0012, 16'h0924, 16'h0000, 16'h0000);
        lyr_sel = ~cur;
        repeat (2) @(negedge clk);
        lyr_sel = cur; en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        check("R11 no swap while disabled", pe_out, 16'h0101);

        // R10: writing during execution leaves active layer alone
        set_data(16'h0200, 16'h0001, 16'h0000);
        lyr_sel = cur; en = 1'b1;
        write_layer(16'h0015, 16'h0924, 16'h0000, 16'h0000);
        en = 1'b0;
        check("R10 active layer unchanged by writes", pe_out, 16'h0201);
        swap_run(16'h0F0F, 16'h00FF, 16'h0000);
        check("R10 written layer used after swap", pe_out, 16'h0FF0);

        // R12: delay mode
        write_layer(16'h0010, 16'h0000, 16'h0001, 16'h0000);
        swap_run(16'hBEEF, 16'h0000, 16'h0000);
        check("R12 lor captures operand A", lor_out, 16'hBEEF);
        write_layer(16'h0010, 16'h0003, 16'h0000, 16'h0000);
        swap_run(16'hCAFE, 16'h0000, 16'h0000);
        check("R12 delayed value read back", pe_out, 16'hCAFE);
        set_data(16'h0001, 16'h0000, 16'h0000);
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        check("R13 hold mode keeps lor", lor_out, 16'hCAFE);
        check("R13 held lor feeds operand", pe_out, 16'hCAFE);

        // R13: coefficient mode
        write_layer(16'h0010, 16'h0000, 16'h0002, 16'h0003);
        swap_run(16'h0000, 16'h0000, 16'h0000);
        check("R13 lor loads coefficient", lor_out, 16'h0003);
        write_layer(16'h0016, 16'h000C, 16'h0000, 16'h0000);
        swap_run(16'h0105, 16'h0000, 16'h0000);
        check("R13 coefficient multiply", pe_out, 16'h030F);
        check("R13 coefficient retained", lor_out, 16'h0003);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule